// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synchronous single-port SRAM model built so that the shared data path never idles when traffic changes direction. Commands are taken on rising clock edges. A read places its word on the output after the next enabled edge. A write expects its data, with one active-low enable per byte, one enabled edge after that. Both directions therefore use the data path in the same cycle relative to their command, so reads and writes can be issued in any mix, one per cycle. Read and write data travel on separate ports. A drive flag together with zeroed read data stand in for a tristate bus.

A new command is loaded when the advance input is low. When advance is high, the block continues a four-beat burst from the last loaded address and steps the two low address bits. The step is linear or interleaved, set by a static order input. An active-high stall input freezes the whole pipeline. An asynchronous output enable masks the read port. A sleep request takes effect two edges after it rises and ends two edges after it falls, and the array keeps its contents throughout. A read that targets a word whose write data is still in flight returns that data, merged lane by lane.

Top module: `zbt_sram_core`

## Requirements
- R1: After reset the read port is not driven: `rdata_oe` is 0 and `rdata` is all zeros.
- R2: A read command (advance low, `cs_n` low, `we_n` high, at an enabled edge) drives the addressed word on `rdata`, with `rdata_oe` high, after the next enabled edge.
- R3: A write command (advance low, `cs_n` low, `we_n` low) takes its data from `wdata` at the second enabled edge after the command edge.
- R4: `wr_lane_n[i]` low updates bits 8i+7..8i of the addressed word. A lane whose bit is high keeps its old value.
- R5: Reads and writes to any addresses can alternate on every enabled edge, with no idle cycle needed between them.
- R6: A read returns the result of all writes issued before it, including writes whose data has not yet reached the array, merged per lane.
- R7: A command with `cs_n` high performs no array access and leaves the read port undriven in the cycle where its data would appear. This holds even when `we_n` is low.
- R8: While `cke_n` is high, edges have no effect: every command, address and data input is ignored, and outputs and pipeline contents hold.
- R9: `oe_n` high forces `rdata_oe` to 0 and `rdata` to 0 without waiting for a clock edge. Lowering it again shows the held word immediately.
- R10: With `burst_order` low, each advance-high edge continues the last command at the next address. The low two bits are (start + n) mod 4 and the upper bits are unchanged, so after four beats the burst wraps to its start.
- R11: With `burst_order` high, the burst low two bits are start XOR n, for n = 1, 2, 3 and then 0.
- R12: Commands at the two edges that sample `zz` high still execute. After that the core sleeps: the read port is undriven, commands are ignored and contents are kept. After `zz` falls, two more edges are ignored, and then the held output and normal operation return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_n | input | 1 | Stall, active high: freezes the core |
| adv | input | 1 | Low: load new command; high: continue burst |
| cs_n | input | 1 | Select, active low; high makes the loaded command a deselect |
| we_n | input | 1 | Low: write, high: read |
| addr | input | ADDR_W | Word address for a new command |
| burst_order | input | 1 | 0 linear, 1 interleaved burst stepping |
| wr_lane_n | input | DATA_W/LANE_W | Active-low byte lane enables, sampled with write data |
| wdata | input | DATA_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep request, active high |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_oe | output | 1 | High while `rdata` carries valid read data |

## Verification
On every cycle the assertions check the gating of the read port by `oe_n` and by sleep, the freezing of the output and first pipeline stage during a stall or sleep, and that only a read in the first stage leads to a driven output. They also check that a burst never leaves its four-word group. Data correctness can only be shown by the bench's scenarios, which compare against a program-order memory model. This covers lane merging, forwarding from in-flight writes, the exact burst address orders and the two-edge entry to and exit from sleep.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] beat,
  input  zbt_pkg::order_e  order,
  output logic [CNT_W-1:0] addr_lo
);
  always_comb begin
    case (order)
      zbt_pkg::ORDER_INTERLEAVED: addr_lo = start_lo ^ beat;
      default:                    addr_lo = start_lo + beat;
    endcase
  end
endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  zbt_pkg::order_e   order,
  output zbt_pkg::op_e      s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output zbt_pkg::op_e      s2_op,
  output logic [ADDR_W-1:0] s2_addr
);
  import zbt_pkg::*;

  op_e               s1_op_q, s1_op_d, s2_op_q, s2_op_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d;
  logic [CNT_W-1:0]  start_q, start_d, beat_q, beat_d, beat_step, burst_lo;

  assign beat_step = beat_q + CNT_W'(1);

  zbt_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .start_lo (start_q),
    .beat     (beat_step),
    .order    (order),
    .addr_lo  (burst_lo)
  );

  always_comb begin
    s1_op_d   = s1_op_q;
    s1_addr_d = s1_addr_q;
    s2_op_d   = s2_op_q;
    s2_addr_d = s2_addr_q;
    start_d   = start_q;
    beat_d    = beat_q;
    if (en) begin
      s2_op_d   = s1_op_q;
      s2_addr_d = s1_addr_q;
      if (!adv) begin
        s1_op_d   = cs_n ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
        s1_addr_d = addr;
        start_d   = addr[CNT_W-1:0];
        beat_d    = '0;
      end else begin
        beat_d    = beat_step;
        s1_addr_d = {s1_addr_q[ADDR_W-1:CNT_W], burst_lo};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= OP_IDLE;
      s1_addr_q <= '0;
      s2_op_q   <= OP_IDLE;
      s2_addr_q <= '0;
      start_q   <= '0;
      beat_q    <= '0;
    end else begin
      s1_op_q   <= s1_op_d;
      s1_addr_q <= s1_addr_d;
      s2_op_q   <= s2_op_d;
      s2_addr_q <= s2_addr_d;
      start_q   <= start_d;
      beat_q    <= beat_d;
    end
  end

  assign s1_op   = s1_op_q;
  assign s1_addr = s1_addr_q;
  assign s2_op   = s2_op_q;
  assign s2_addr = s2_addr_q;
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  zbt_pkg::op_e               s1_op,
  input  logic [ADDR_W-1:0]          s1_addr,
  input  zbt_pkg::op_e               s2_op,
  input  logic [ADDR_W-1:0]          s2_addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W/LANE_W-1:0]   wr_lane_n,
  output logic [DATA_W-1:0]          out_q,
  output logic                       out_vld
);
  import zbt_pkg::*;

  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wr_word, rd_word, out_d;
  logic              wr_fire, fwd_hit, out_vld_d;

  assign wr_fire = en && (s2_op == OP_WRITE);
  assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_word[g*LANE_W +: LANE_W] = wr_lane_n[g] ? mem[s2_addr][g*LANE_W +: LANE_W]
                                                      : wdata[g*LANE_W +: LANE_W];
    assign rd_word[g*LANE_W +: LANE_W] = (fwd_hit && !wr_lane_n[g]) ? wdata[g*LANE_W +: LANE_W]
                                                                    : mem[s1_addr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[s2_addr] <= wr_word;
  end

  always_comb begin
    out_d     = out_q;
    out_vld_d = out_vld;
    if (en) begin
      out_vld_d = (s1_op == OP_READ);
      if (s1_op == OP_READ) out_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      out_vld <= 1'b0;
    end else begin
      out_q   <= out_d;
      out_vld <= out_vld_d;
    end
  end
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke_n,
  input  logic                     adv,
  input  logic                     cs_n,
  input  logic                     we_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     burst_order,
  input  logic [DATA_W/LANE_W-1:0] wr_lane_n,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     oe_n,
  input  logic                     zz,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_oe
);
  import zbt_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [1:0]        zz_q, zz_d;
  logic              asleep, core_en, drive;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [DATA_W-1:0] out_q;
  logic              out_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign zz_d = {zz_q[0], zz};
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) zz_q <= 2'b00;
    else             zz_q <= zz_d;
  end

  assign asleep  = zz_q[1];
  assign core_en = !cke_n && !asleep;

  zbt_cmd_pipe #(.ADDR_W(ADDR_W), .CNT_W(BURST_W)) u_pipe (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .en      (core_en),
    .adv     (adv),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .addr    (addr),
    .order   (order_e'(burst_order)),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s2_op   (s2_op),
    .s2_addr (s2_addr)
  );

  zbt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .en        (core_en),
    .s1_op     (s1_op),
    .s1_addr   (s1_addr),
    .s2_op     (s2_op),
    .s2_addr   (s2_addr),
    .wdata     (wdata),
    .wr_lane_n (wr_lane_n),
    .out_q     (out_q),
    .out_vld   (out_vld)
  );

  assign drive    = out_vld && !oe_n && !asleep;
  assign rdata_oe = drive;
  assign rdata    = drive ? out_q : '0;
endmodule

// File: rtl/zbt_sram_core_checker.sv
module zbt_sram_core_checker #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              adv,
  input logic              oe_n,
  input logic              asleep,
  input logic              core_en,
  input zbt_pkg::op_e      s1_op,
  input logic [ADDR_W-1:0] s1_addr,
  input logic [DATA_W-1:0] out_q,
  input logic              out_vld,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe
);
  import zbt_pkg::*;

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe);

  assert_undriven_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

  assert_sleep_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !rdata_oe);

  assert_sleep_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> ($stable(out_q) && $stable(out_vld) && $stable(s1_addr) && $stable(s1_op)));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(out_q) && $stable(out_vld) && $stable(s1_addr) && $stable(s1_op)));

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && s1_op == OP_READ) |=> out_vld);

  assert_nonread_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && s1_op != OP_READ) |=> !out_vld);

  assert_burst_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && adv) |=> (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])));
endmodule

bind zbt_sram_core zbt_sram_core_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W)
) u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .cke_n    (cke_n),
  .adv      (adv),
  .oe_n     (oe_n),
  .asleep   (asleep),
  .core_en  (core_en),
  .s1_op    (s1_op),
  .s1_addr  (s1_addr),
  .out_q    (out_q),
  .out_vld  (out_vld),
  .rdata    (rdata),
  .rdata_oe (rdata_oe)
);

// File: tb/zbt_sram_core_bench.sv
module zbt_sram_core_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke_n, adv, cs_n, we_n, burst_order, oe_n, zz;
  logic [7:0]  addr;
  logic [3:0]  wr_lane_n;
  logic [31:0] wdata, rdata;
  logic        rdata_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] mem_m [256];
  int          h1_kind = 0, h2_kind = 0;
  logic [31:0] h1_wd = '0, h2_wd = '0, h1_exp = '0;
  logic [3:0]  h1_be = 4'hF, h2_be = 4'hF;
  logic [7:0]  b_base = '0;
  logic [1:0]  b_cnt = '0;
  int          b_kind = 0;
  bit          asleep_m = 0;

  always #5 clk = ~clk;

  zbt_sram_core u_zbt_sram_core (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .cs_n(cs_n), .we_n(we_n),
    .addr(addr), .burst_order(burst_order), .wr_lane_n(wr_lane_n), .wdata(wdata),
    .oe_n(oe_n), .zz(zz), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h (oe=%b)", req, act, exp, rdata_oe);
    end
  endtask

  // One enabled edge; kind 0 idle, 1 read, 2 write. Checks the command of the previous edge.
  task automatic step(input string req, input logic a_adv, input logic a_cs_n, input logic a_we_n,
                      input logic [7:0] a_addr, input logic [31:0] a_wd, input logic [3:0] a_be_n);
    int kind;
    logic [7:0] eff;
    logic [31:0] ex;
    if (!a_adv) begin
      kind = a_cs_n ? 0 : (a_we_n ? 1 : 2);
      b_base = a_addr; b_cnt = 2'd0; b_kind = kind; eff = a_addr;
    end else begin
      b_cnt = b_cnt + 2'd1; kind = b_kind;
      eff = {b_base[7:2], burst_order ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
    end
    ex = mem_m[eff];
    if (kind == 2)
      for (int l = 0; l < 4; l++)
        if (!a_be_n[l]) mem_m[eff][l*8 +: 8] = a_wd[l*8 +: 8];
    adv = a_adv; cs_n = a_cs_n; we_n = a_we_n; addr = a_addr;
    wdata     = (h2_kind == 2) ? h2_wd : 32'h0BAD_F00D;
    wr_lane_n = (h2_kind == 2) ? h2_be : 4'hF;
    @(posedge clk); #1;
    if (h1_kind == 1 && !oe_n && !asleep_m)
      chk(req, rdata_oe === 1'b1 && rdata === h1_exp, rdata, h1_exp);
    else
      chk(req, rdata_oe === 1'b0 && rdata === 32'h0, rdata, 32'h0);
    h2_kind = h1_kind; h2_wd = h1_wd; h2_be = h1_be;
    h1_kind = kind; h1_wd = a_wd; h1_be = a_be_n; h1_exp = ex;
  endtask

  task automatic nop(input string req);
    step(req, 1'b0, 1'b1, 1'b1, 8'h00, 32'h0, 4'hF);
  endtask
  task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    step(req, 1'b0, 1'b0, 1'b0, a, d, be);
  endtask
  task automatic rd(input string req, input logic [7:0] a);
    step(req, 1'b0, 1'b0, 1'b1, a, 32'h0, 4'hF);
  endtask
  task automatic burst(input string req, input logic [31:0] d);
    step(req, 1'b1, 1'b0, 1'b0, 8'h00, d, 4'h0);
  endtask

  // An edge the core must ignore (stall or sleep), carrying a junk write to a.
  task automatic raw_edge(input string req, input logic stall, input logic [7:0] a, input bit do_chk);
    logic [31:0] pd;
    logic        po;
    pd = rdata; po = rdata_oe;
    cke_n = stall; adv = 1'b0; cs_n = 1'b0; we_n = 1'b0; addr = a;
    @(posedge clk); #1;
    cke_n = 1'b0;
    if (do_chk) chk(req, rdata === pd && rdata_oe === po, rdata, pd);
  endtask

  task automatic t_reset();
    chk("R1", rdata_oe === 1'b0 && rdata === 32'h0, rdata, 32'h0);
  endtask

  task automatic t_write_read();
    wr("R3", 8'h10, 32'h1122_3344, 4'h0);
    nop("R3"); nop("R3"); nop("R3");
    rd("R2", 8'h10);
    nop("R2");
    nop("R2");
  endtask

  task automatic t_lanes();
    wr("R4", 8'h20, 32'hAAAA_AAAA, 4'h0);
    nop("R4"); nop("R4");
    wr("R4", 8'h20, 32'h5566_7788, 4'b1010);
    nop("R4"); nop("R4"); nop("R4");
    rd("R4", 8'h20);
    nop("R4"); nop("R4");
  endtask

  task automatic t_alternate();
    wr("R5", 8'h30, 32'h3000_0001, 4'h0);
    rd("R5", 8'h10);
    wr("R5", 8'h31, 32'h3100_0002, 4'h0);
    rd("R5", 8'h20);
    wr("R5", 8'h32, 32'h3200_0003, 4'h0);
    rd("R5", 8'h30);
    rd("R5", 8'h31);
    wr("R5", 8'h10, 32'h1010_1010, 4'h0);
    rd("R5", 8'h32);
    nop("R5"); nop("R5");
  endtask

  task automatic t_coherent();
    wr("R6", 8'h40, 32'hC0DE_0000, 4'h0);
    rd("R6", 8'h40);
    wr("R6", 8'h40, 32'h0000_BEEF, 4'b1100);
    rd("R6", 8'h40);
    wr("R6", 8'h41, 32'h1234_5678, 4'h0);
    wr("R6", 8'h41, 32'hFFFF_FFFF, 4'b1110);
    rd("R6", 8'h41);
    nop("R6"); nop("R6");
  endtask

  task automatic t_deselect();
    step("R7", 1'b0, 1'b1, 1'b0, 8'h10, 32'hDEAD_DEAD, 4'h0);
    step("R7", 1'b0, 1'b1, 1'b1, 8'h10, 32'h0, 4'hF);
    nop("R7"); nop("R7");
    rd("R7", 8'h10);
    nop("R7"); nop("R7");
  endtask

  task automatic t_stall();
    rd("R8", 8'h30);
    raw_edge("R8", 1'b1, 8'h30, 1'b1);
    raw_edge("R8", 1'b1, 8'h30, 1'b1);
    nop("R8");
    wr("R8", 8'h33, 32'h3333_0000, 4'h0);
    nop("R8");
    raw_edge("R8", 1'b1, 8'h33, 1'b1);
    nop("R8"); nop("R8");
    rd("R8", 8'h30);
    rd("R8", 8'h33);
    nop("R8"); nop("R8");
  endtask

  task automatic t_oe();
    rd("R9", 8'h20);
    oe_n = 1'b1;
    nop("R9");
    oe_n = 1'b0; #1;
    chk("R9", rdata_oe === 1'b1 && rdata === mem_m[8'h20], rdata, mem_m[8'h20]);
    oe_n = 1'b1; #1;
    chk("R9", rdata_oe === 1'b0 && rdata === 32'h0, rdata, 32'h0);
    oe_n = 1'b0;
    nop("R9"); nop("R9");
  endtask

  task automatic t_burst_linear();
    burst_order = 1'b0;
    wr("R10", 8'h42, 32'hB000_0000, 4'h0);
    burst("R10", 32'hB000_0001);
    burst("R10", 32'hB000_0002);
    burst("R10", 32'hB000_0003);
    nop("R10"); nop("R10"); nop("R10");
    rd("R10", 8'h43);
    for (int i = 0; i < 4; i++) step("R10", 1'b1, 1'b0, 1'b1, 8'h00, 32'h0, 4'hF);
    nop("R10");
    rd("R10", 8'h40);
    nop("R10"); nop("R10");
  endtask

  task automatic t_burst_interleaved();
    burst_order = 1'b0;
    for (int i = 0; i < 4; i++) wr("R11", 8'h84 + 8'(i), 32'h8400_0000 + 32'(i * 17), 4'h0);
    nop("R11"); nop("R11");
    burst_order = 1'b1;
    rd("R11", 8'h86);
    for (int i = 0; i < 3; i++) step("R11", 1'b1, 1'b0, 1'b1, 8'h00, 32'h0, 4'hF);
    rd("R11", 8'h85);
    for (int i = 0; i < 4; i++) step("R11", 1'b1, 1'b0, 1'b1, 8'h00, 32'h0, 4'hF);
    nop("R11"); nop("R11");
    burst_order = 1'b0;
  endtask

  task automatic t_sleep();
    wr("R12", 8'h50, 32'h5A5A_0050, 4'h0);
    nop("R12"); nop("R12"); nop("R12");
    zz = 1'b1;
    rd("R12", 8'h50);
    asleep_m = 1;
    nop("R12");
    wdata = 32'hFFFF_FFFF; wr_lane_n = 4'h0;
    for (int i = 0; i < 3; i++) raw_edge("R12", 1'b0, 8'h50, 1'b1);
    zz = 1'b0;
    raw_edge("R12", 1'b0, 8'h50, 1'b1);
    raw_edge("R12", 1'b0, 8'h50, 1'b0);
    asleep_m = 0;
    chk("R12", rdata_oe === 1'b1 && rdata === mem_m[8'h50], rdata, mem_m[8'h50]);
    nop("R12");
    rd("R12", 8'h50);
    nop("R12"); nop("R12");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = '0;
    rst_n = 1'b0; cke_n = 1'b0; adv = 1'b0; cs_n = 1'b1; we_n = 1'b1; addr = '0;
    burst_order = 1'b0; wr_lane_n = 4'hF; wdata = '0; oe_n = 1'b0; zz = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_write_read();
    t_lanes();
    t_alternate();
    t_coherent();
    t_deselect();
    t_stall();
    t_oe();
    t_burst_linear();
    t_burst_interleaved();
    t_sleep();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #200_000ns;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule